// File: doc/BRIEF.md
# Capability Load Permission Filter

This block sits between the memory read path and the register file write port. It handles a capability that a load has just returned. Two capabilities are involved: the one that authorised the load, and the one that came back from memory. Permissions on the returned capability are weakened according to what the authorising capability lacks. Loading through a capability therefore never yields more authority than that capability carries over transitively.

The block also acts as a load barrier. Every capability-sized granule of memory has a revocation bit beside its validity tag. For a tagged result, the block sends the granule index of the loaded capability's base address to a one-cycle-latency revocation-bit memory over a request/valid handshake. The block then clears the tag if that bit is set. Untagged data passes straight through and does not query the memory.

The block takes one load at a time. It shows it is idle on `in_ready`. The filtered result appears for exactly one cycle on `out_valid`.

Top module: `cap_load_filter`

## Requirements
Permission bit positions: bit 0 global, bit 1 keep-global, bit 2 load, bit 3 store, bit 4 capability-memory, bit 5 keep-writable. Bits 6 and up carry no filtering meaning.

- R1: During and immediately after reset, `out_valid` and `rv_req` are 0 and `in_ready` is 1.
- R2: For a tagged load whose authorising permissions have load (bit 2) and capability-memory (bit 4) set but keep-writable (bit 5) clear, the output clears store (bit 3) and keep-writable (bit 5). If load or capability-memory is missing from the authorising permissions, this rule does not apply.
- R3: For a tagged load whose authorising permissions lack keep-global (bit 1), the output clears global (bit 0) and keep-global (bit 1).
- R4: The rules of R2 and R3 apply independently and may both apply. Every other permission bit, and the whole base address, reach the output unchanged.
- R5: An untagged load is output with tag 0 and its permissions unchanged, one cycle after acceptance, and `rv_req` stays 0.
- R6: The revocation request carries the granule index, which is the loaded base shifted right by log2(CAP_BYTES) (3 for the default 8-byte capability).
- R7: A tagged load whose granule's revocation bit reads 1 is output with tag 0. If the bit reads 0, the tag stays 1.
- R8: For a tagged load, `rv_req` is a single-cycle pulse in the cycle after acceptance. `out_valid` rises only in the cycle after `rv_valid`, so a tagged result appears three cycles after acceptance.
- R9: A load is accepted only while `in_ready` is 1. A load offered while busy is ignored: it changes neither the pending result nor the number of results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A returned capability is offered |
| in_ready | output | 1 | Block idle, offer is taken this cycle |
| auth_perms | input | PERM_W | Permissions of the authorising capability |
| ld_tag | input | 1 | Validity tag of the loaded capability |
| ld_perms | input | PERM_W | Permissions of the loaded capability |
| ld_base | input | ADDR_W | Base address of the loaded capability |
| rv_req | output | 1 | Revocation-bit read request |
| rv_index | output | ADDR_W-log2(CAP_BYTES) | Granule index to read |
| rv_valid | input | 1 | Revocation bit returned |
| rv_bit | input | 1 | Revocation bit value |
| out_valid | output | 1 | Filtered capability valid this cycle |
| out_tag | output | 1 | Filtered tag |
| out_perms | output | PERM_W | Filtered permissions |
| out_base | output | ADDR_W | Base address, unchanged |

## Verification
The assertions check on every cycle the handshake shape. `rv_req` is a one-cycle pulse and never occurs while the block reports idle. The requested index matches the base offered one cycle earlier. A tagged result never appears without a response in the cycle before it, and a revoked response always yields a cleared tag. The permission rules depend on which authorising bits are present, and the effect of busy-time offers depends on the pending load. Only the bench's scenarios can show these, by computing every output field and comparing it in each cycle of every transaction.

// File: rtl/cap_filter_pkg.sv
// Package: shared permission bit positions and controller states for the
// capability load filter. Positions are fixed; widths beyond them are free.
package cap_filter_pkg;

    localparam int PERM_W_DEF = 12;

    // Permission bit positions that the filter decodes
    localparam int P_GLOBAL  = 0;
    localparam int P_KEEPGLB = 1;
    localparam int P_LOAD    = 2;
    localparam int P_STORE   = 3;
    localparam int P_CAPMEM  = 4;
    localparam int P_KEEPWR  = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_OUT  = 2'd3
    } fstate_t;

endpackage

// File: rtl/perm_attenuator.sv
// Module: perm_attenuator
// Weakens the loaded permission vector according to the authorising one.
// Assumes PERM_W > P_KEEPWR. Purely combinational; untagged data is passed
// through untouched.
module perm_attenuator
    import cap_filter_pkg::*;
#(
    parameter int PERM_W = PERM_W_DEF
) (
    input  logic              tag,
    input  logic [PERM_W-1:0] auth_perms,
    input  logic [PERM_W-1:0] perms_in,
    output logic [PERM_W-1:0] perms_out
);

    logic strip_wr;
    logic strip_glb;
    logic [PERM_W-1:0] kill;

    // Decide which of the two stripping rules fire
    always_comb begin
        strip_wr  = tag && auth_perms[P_LOAD] && auth_perms[P_CAPMEM]
                        && !auth_perms[P_KEEPWR];
        strip_glb = tag && !auth_perms[P_KEEPGLB];
    end

    // Per-bit kill mask and masking
    for (genvar i = 0; i < PERM_W; i++) begin : g_bit
        if (i == P_STORE || i == P_KEEPWR) begin : g_wr
            assign kill[i] = strip_wr;
        end else if (i == P_GLOBAL || i == P_KEEPGLB) begin : g_glb
            assign kill[i] = strip_glb;
        end else begin : g_keep
            assign kill[i] = 1'b0;
        end
        assign perms_out[i] = perms_in[i] & ~kill[i];
    end

endmodule

// File: rtl/granule_index.sv
// Module: granule_index
// Maps a byte address to the index of its capability-sized granule.
// Assumes CAP_BYTES is a power of two.
module granule_index #(
    parameter int ADDR_W    = 32,
    parameter int CAP_BYTES = 8,
    localparam int SHIFT    = $clog2(CAP_BYTES),
    localparam int IDX_W    = ADDR_W - SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    logic [ADDR_W-1:0] shifted;

    // Drop the byte-within-granule bits
    always_comb begin
        shifted = addr >> SHIFT;
        idx     = shifted[IDX_W-1:0];
    end

endmodule

// File: rtl/filter_ctrl.sv
// Module: filter_ctrl
// Sequencer: accepts one load when idle, issues a single revocation request
// for tagged loads, waits for the response, then presents the result for one
// cycle. Assumes the bit memory answers each request exactly once.
module filter_ctrl
    import cap_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic ld_tag,
    input  logic rv_valid,
    output logic in_ready,
    output logic accept,
    output logic rv_req,
    output logic resp_take,
    output logic out_valid
);

    fstate_t state_q;
    fstate_t state_d;

    // Handshake strobes decoded from the current state
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        accept    = in_ready && in_valid;
        rv_req    = (state_q == ST_REQ);
        resp_take = (state_q == ST_WAIT) && rv_valid;
        out_valid = (state_q == ST_OUT);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ld_tag ? ST_REQ : ST_OUT;
            ST_REQ:  state_d = ST_WAIT;
            ST_WAIT: if (rv_valid) state_d = ST_OUT;
            ST_OUT:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/cap_load_filter.sv
// Module: cap_load_filter (top)
// Post-processes a loaded capability: attenuates permissions through the
// authorising capability and clears the tag if the base granule is revoked.
// Assumes a one-cycle-latency revocation memory on the rv_* handshake.
module cap_load_filter
    import cap_filter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PERM_W    = PERM_W_DEF,
    parameter int CAP_BYTES = 8,
    localparam int IDX_W    = ADDR_W - $clog2(CAP_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PERM_W-1:0] auth_perms,
    input  logic              ld_tag,
    input  logic [PERM_W-1:0] ld_perms,
    input  logic [ADDR_W-1:0] ld_base,
    output logic              rv_req,
    output logic [IDX_W-1:0]  rv_index,
    input  logic              rv_valid,
    input  logic              rv_bit,
    output logic              out_valid,
    output logic              out_tag,
    output logic [PERM_W-1:0] out_perms,
    output logic [ADDR_W-1:0] out_base
);

    logic              accept;
    logic              resp_take;
    logic [PERM_W-1:0] atten_perms;
    logic              tag_q;
    logic              revoked_q;
    logic [PERM_W-1:0] perms_q;
    logic [ADDR_W-1:0] base_q;

    filter_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ld_tag    (ld_tag),
        .rv_valid  (rv_valid),
        .in_ready  (in_ready),
        .accept    (accept),
        .rv_req    (rv_req),
        .resp_take (resp_take),
        .out_valid (out_valid)
    );

    perm_attenuator #(.PERM_W(PERM_W)) u_atten (
        .tag        (ld_tag),
        .auth_perms (auth_perms),
        .perms_in   (ld_perms),
        .perms_out  (atten_perms)
    );

    granule_index #(.ADDR_W(ADDR_W), .CAP_BYTES(CAP_BYTES)) u_gidx (
        .addr (base_q),
        .idx  (rv_index)
    );

    // Capture the accepted load with its permissions already attenuated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= 1'b0;
            perms_q <= '0;
            base_q  <= '0;
        end else if (accept) begin
            tag_q   <= ld_tag;
            perms_q <= atten_perms;
            base_q  <= ld_base;
        end
    end

    // Record the revocation verdict for the pending load
    always_ff @(posedge clk) begin
        if (!rst_n)         revoked_q <= 1'b0;
        else if (accept)    revoked_q <= 1'b0;
        else if (resp_take) revoked_q <= rv_bit;
    end

    // Drive the filtered result
    always_comb begin
        out_tag   = tag_q & ~revoked_q;
        out_perms = perms_q;
        out_base  = base_q;
    end

endmodule

// File: rtl/cap_filter_checker.sv
// Module: cap_filter_checker
// Protocol properties of the load filter, bound onto the top module.
module cap_filter_checker #(
    parameter int ADDR_W    = 32,
    parameter int CAP_BYTES = 8,
    localparam int SHIFT    = $clog2(CAP_BYTES),
    localparam int IDX_W    = ADDR_W - SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              ld_tag,
    input logic [ADDR_W-1:0] ld_base,
    input logic              rv_req,
    input logic [IDX_W-1:0]  rv_index,
    input logic              rv_valid,
    input logic              rv_bit,
    input logic              out_valid,
    input logic              out_tag
);

    logic [ADDR_W-1:0] base_sh;
    assign base_sh = ld_base >> SHIFT;

    // R8: request lasts exactly one cycle
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rv_req |=> !rv_req);

    // R9: never idle while a request is out
    a_r9_busy_during_req: assert property (@(posedge clk) disable iff (!rst_n)
        rv_req |-> !in_ready);

    // R5: untagged acceptance issues no lookup
    a_r5_untagged_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !ld_tag) |=> !rv_req);

    // R6: index equals the base offered at acceptance, shifted
    a_r6_index: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ld_tag) |=> (rv_index == $past(base_sh[IDX_W-1:0])));

    // R8: a tagged result only follows a response
    a_r8_valid_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tag) |-> $past(rv_valid));

    // R7: revoked response clears the tag
    a_r7_revoked_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rv_valid && rv_bit) && out_valid) |-> !out_tag);

endmodule

bind cap_load_filter cap_filter_checker #(
    .ADDR_W    (ADDR_W),
    .CAP_BYTES (CAP_BYTES)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ld_tag    (ld_tag),
    .ld_base   (ld_base),
    .rv_req    (rv_req),
    .rv_index  (rv_index),
    .rv_valid  (rv_valid),
    .rv_bit    (rv_bit),
    .out_valid (out_valid),
    .out_tag   (out_tag)
);

// File: tb/cap_load_filter_bench.sv
module cap_load_filter_bench;
    import cap_filter_pkg::*;

    localparam int AW = 32;
    localparam int PW = 12;
    localparam int IW = AW - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [PW-1:0] auth_perms = '0;
    logic ld_tag = 1'b0;
    logic [PW-1:0] ld_perms = '0;
    logic [AW-1:0] ld_base = '0;
    logic rv_req;
    logic [IW-1:0] rv_index;
    logic rv_valid = 1'b0;
    logic rv_bit = 1'b0;
    logic out_valid;
    logic out_tag;
    logic [PW-1:0] out_perms;
    logic [AW-1:0] out_base;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cap_load_filter u_cap_load_filter (.*);

    // Behavioural revocation memory: bit pattern computed from the index
    function automatic logic revoked(input logic [IW-1:0] idx);
        return idx[1] ^ idx[4];
    endfunction

    always @(posedge clk) begin
        rv_valid <= rst_n && rv_req;
        rv_bit   <= revoked(rv_index);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One load through the model; optionally offer a second load while busy
    task automatic run(input logic [PW-1:0] a, input logic t, input logic [PW-1:0] p,
                       input logic [AW-1:0] b, input bit poke);
        logic [PW-1:0] ep;
        logic etag;
        logic [IW-1:0] eidx;
        int lat;
        ep = p;
        eidx = IW'(b >> 3);
        if (t) begin
            if (a[P_LOAD] && a[P_CAPMEM] && !a[P_KEEPWR]) begin
                ep[P_STORE] = 1'b0; ep[P_KEEPWR] = 1'b0;   // R2
            end
            if (!a[P_KEEPGLB]) begin
                ep[P_GLOBAL] = 1'b0; ep[P_KEEPGLB] = 1'b0; // R3
            end
        end
        etag = t && !revoked(eidx);                          // R7
        lat = t ? 3 : 1;
        @(negedge clk);
        chk("R9 ready before offer", 64'(in_ready), 64'(1));
        in_valid = 1'b1; auth_perms = a; ld_tag = t; ld_perms = p; ld_base = b;
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            if (i == 1) begin
                in_valid = poke;
                if (poke) begin
                    auth_perms = '0; ld_tag = 1'b1; ld_perms = '1; ld_base = ~b;
                end
                chk(t ? "R8 req pulse" : "R5 no req", 64'(rv_req), 64'(t));
                if (t) chk("R6 index", 64'(rv_index), 64'(eidx));
            end else begin
                chk("R8 no early req", 64'(rv_req), 64'(0));
                if (i == 2) in_valid = 1'b0;
            end
            chk("R8 valid timing", 64'(out_valid), 64'(i == lat));
        end
        chk("R7 tag", 64'(out_tag), 64'(etag));
        chk("R4 perms", 64'(out_perms), 64'(ep));
        chk("R4 base", 64'(out_base), 64'(b));
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 single result", 64'(out_valid), 64'(0));
        chk("R9 idle again", 64'(in_ready), 64'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'(0));
        chk("R1 rv_req", 64'(rv_req), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 64'(in_ready), 64'(1));
        chk("R1 out_valid after", 64'(out_valid), 64'(0));
        // R2 fires, R3 quiet
        run(12'h016, 1'b1, 12'hFFF, 32'h0000_0040, 0);
        // R2 quiet: auth lacks capability-memory
        run(12'h006, 1'b1, 12'hFFF, 32'h0000_0048, 0);
        // R3 fires alone
        run(12'h03C, 1'b1, 12'hFFF, 32'h0000_0100, 0);
        // R4 both fire, revoked granule (R7)
        run(12'h014, 1'b1, 12'hA5F, 32'h0000_0010, 0);
        // R5 untagged unchanged
        run(12'h000, 1'b0, 12'h3C3, 32'h1234_5678, 0);
        // R9 busy offer ignored
        run(12'hFFF, 1'b1, 12'h0F0, 32'h8000_0080, 1);
        // R6 high address, full authority
        run(12'hFFF, 1'b1, 12'hFFF, 32'hFFFF_FFF8, 0);
        for (int k = 0; k < 24; k++)
            run(PW'(k * 7 + 3), k[0], PW'(k * 157), 32'(k * 40), k[1] & k[2]);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule